// File: doc/BRIEF.md
# Host-Write to SPI Flash Program Bridge

This block sits between a simple host write port and a serial flash device. When the host issues a memory write and the path is enabled, the block captures the flash address, the write data and the program opcode, then builds a transmit frame. The frame is the opcode, the address with its most significant byte first, and then the data bytes with the lowest byte first. It shifts the frame out over an SPI master port in mode 0.

The host sees a long-wait status while the frame is in flight. When the chip select has been released, the status shows ready for one cycle and then turnaround for one cycle. A byte-wide write yields a single-byte program frame. Wider writes put two or four data bytes into the same frame. The opcode comes from an input that software loads, so the same path can issue any program command.

Top module: `flash_prog_bridge`

## Requirements
- R1: A write request is accepted only when `cfg_autoinc`=0, `cfg_dummy`=0, `cfg_direct`=1 and `cfg_hold_host`=1. With any other setting the status stays idle (code 0) and no frame is sent.
- R2: In the cycle after an accepted request, `host_stat` shows long-wait (code 1). It stays at long-wait for the whole frame, and `spi_cs_n` is low only while the status is long-wait.
- R3: The frame carries these bytes in order: the opcode, address[23:16], address[15:8], address[7:0], and then data[7:0], data[15:8], data[23:16], data[31:24], cut to the data length.
- R4: The `wr_size` code sets the data length. Code 0 gives 1 byte, code 1 gives 2 bytes, and codes 2 and 3 give 4 bytes. The frame therefore holds 5, 6 or 8 bytes.
- R5: Each byte is sent most significant bit first in SPI mode 0. `spi_sck` is low whenever `spi_cs_n` is high, and `spi_mosi` is valid at each rising edge of `spi_sck`.
- R6: `spi_cs_n` rises exactly 2*SCK_HALF clock cycles after the last falling edge of `spi_sck`. That is one full SCK period.
- R7: One cycle after `spi_cs_n` rises, `host_stat` shows ready (code 2) for one cycle, then turnaround (code 3) for one cycle, then idle (code 0).
- R8: A request that arrives while the status is not idle is ignored. This covers the frame, the ready cycle and the turnaround cycle. The frame in progress is unchanged and no second frame follows.
- R9: The opcode, address, data and size are captured in the cycle the request is accepted. Changing these inputs later does not alter the frame.
- R10: A synchronous active-high `rst`, even in the middle of a frame, returns the block to idle with `spi_cs_n` high, `spi_sck` low and status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_autoinc | input | 1 | Address auto-increment mode enable; must be 0 for this path |
| cfg_dummy | input | 1 | Dummy-cycle mode enable; must be 0 for this path |
| cfg_direct | input | 1 | Direct translation of host writes; must be 1 |
| cfg_hold_host | input | 1 | Allow holding the host in long-wait; must be 1 |
| prog_op | input | 8 | Program opcode loaded by software (typically 0x02) |
| wr_req | input | 1 | Host write request, one cycle |
| wr_size | input | 2 | Write size code: 0=1 byte, 1=2 bytes, 2/3=4 bytes |
| wr_addr | input | 24 | Flash byte address |
| wr_data | input | 32 | Write data |
| host_stat | output | 2 | 0 idle, 1 long-wait, 2 ready, 3 turnaround |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Flash chip select, active low |

## Verification
A new host request can land in the same cycle as the completion handshake, which is the ready or turnaround step. It can also land in the middle of shifting. The bench holds `wr_req` high across the ready and turnaround cycles, and pulses it partway through a frame with different address and data. It then requires that the completed frame matches the first request bit for bit, that the status walks ready, turnaround, idle, and that `spi_cs_n` stays high afterwards. The capture of the frame and a change in the host inputs also coincide on the cycle after acceptance. The bench inverts every input there and compares the shifted bits with the values it originally drove.

// File: rtl/fpb_pkg.sv
package fpb_pkg;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_LWAIT = 2'd1,
        HS_READY = 2'd2,
        HS_TURN  = 2'd3
    } host_stat_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_SEND,
        SQ_READY,
        SQ_TURN
    } seq_state_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_BITS,
        SH_HOLD
    } shift_state_e;

endpackage

// File: rtl/fpb_frame_pack.sv
// Maps opcode, address (high byte first) and data (low byte first)
// onto the fixed transmit entries.
module fpb_frame_pack #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned ADDR_BYTES = ADDR_W / 8,
    localparam int unsigned DATA_BYTES = DATA_W / 8,
    localparam int unsigned NB = 1 + ADDR_BYTES + DATA_BYTES
) (
    input  logic [7:0]          opcode,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   data,
    output logic [NB-1:0][7:0]  entries
);

    assign entries[0] = opcode;

    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_addr
        assign entries[1 + i] = addr[ADDR_W - 1 - 8 * i -: 8];
    end

    for (genvar j = 0; j < DATA_BYTES; j++) begin : g_data
        assign entries[1 + ADDR_BYTES + j] = data[8 * j +: 8];
    end

endmodule

// File: rtl/fpb_spi_shift.sv
// Mode-0 serialiser: entry 0 upward, MSB first, CS held one SCK period
// after the last falling SCK edge.
module fpb_spi_shift import fpb_pkg::*; #(
    parameter int unsigned NB       = 8,
    parameter int unsigned SCK_HALF = 2,
    localparam int unsigned IDX_W = $clog2(NB),
    localparam int unsigned CNT_W = $clog2(2 * SCK_HALF) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [NB-1:0][7:0]  frame,
    input  logic [IDX_W-1:0]    last_idx,
    output logic                sck,
    output logic                mosi,
    output logic                cs_n,
    output logic                done
);

    typedef struct packed {
        shift_state_e          st;
        logic [NB-1:0][7:0]    buffer;
        logic [IDX_W-1:0]      byte_i;
        logic [2:0]            bit_i;
        logic [IDX_W-1:0]      last;
        logic [CNT_W-1:0]      cnt;
        logic                  sck;
        logic                  cs_n;
        logic                  done;
    } sh_regs_t;

    sh_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            SH_IDLE: begin
                if (start) begin
                    d.st     = SH_BITS;
                    d.buffer = frame;
                    d.last   = last_idx;
                    d.byte_i = '0;
                    d.bit_i  = 3'd7;
                    d.cnt    = '0;
                    d.sck    = 1'b0;
                    d.cs_n   = 1'b0;
                end
            end
            SH_BITS: begin
                if (q.cnt == CNT_W'(SCK_HALF - 1)) begin
                    d.cnt = '0;
                    if (!q.sck) begin
                        d.sck = 1'b1;
                    end else begin
                        d.sck = 1'b0;
                        if (q.bit_i == 3'd0) begin
                            if (q.byte_i == q.last) begin
                                d.st = SH_HOLD;
                            end else begin
                                d.byte_i = IDX_W'(q.byte_i + 1'b1);
                                d.bit_i  = 3'd7;
                            end
                        end else begin
                            d.bit_i = q.bit_i - 3'd1;
                        end
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SH_HOLD: begin
                if (q.cnt == CNT_W'(2 * SCK_HALF - 1)) begin
                    d.cnt  = '0;
                    d.cs_n = 1'b1;
                    d.done = 1'b1;
                    d.st   = SH_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d.st   = SH_IDLE;
                d.cs_n = 1'b1;
                d.sck  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck  = q.sck;
    assign cs_n = q.cs_n;
    assign done = q.done;
    assign mosi = ~q.cs_n & q.buffer[q.byte_i][q.bit_i];

endmodule

// File: rtl/fpb_seq.sv
// Accepts gated host writes, latches the request and drives the host
// handshake: long-wait, ready, turnaround.
module fpb_seq import fpb_pkg::*; #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 3,
    localparam int unsigned ADDR_BYTES = ADDR_W / 8,
    localparam int unsigned DATA_BYTES = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_autoinc,
    input  logic               cfg_dummy,
    input  logic               cfg_direct,
    input  logic               cfg_hold_host,
    input  logic               req,
    input  logic [1:0]         size,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  data,
    input  logic [7:0]         opcode,
    input  logic               tx_done,
    output logic               tx_start,
    output logic [7:0]         lat_op,
    output logic [ADDR_W-1:0]  lat_addr,
    output logic [DATA_W-1:0]  lat_data,
    output logic [IDX_W-1:0]   last_idx,
    output host_stat_e         stat
);

    typedef struct packed {
        seq_state_e          st;
        logic [7:0]          op;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic [IDX_W-1:0]    last;
    } seq_regs_t;

    seq_regs_t q, d;
    logic      path_ok;
    int unsigned n_data;

    assign path_ok = ~cfg_autoinc & ~cfg_dummy & cfg_direct & cfg_hold_host;

    always_comb begin
        case (size)
            2'd0:    n_data = 1;
            2'd1:    n_data = (DATA_BYTES >= 2) ? 2 : DATA_BYTES;
            default: n_data = DATA_BYTES;
        endcase
    end

    always_comb begin
        d = q;
        case (q.st)
            SQ_IDLE: begin
                if (req && path_ok) begin
                    d.st   = SQ_LOAD;
                    d.op   = opcode;
                    d.addr = addr;
                    d.data = data;
                    d.last = IDX_W'(ADDR_BYTES + n_data);
                end
            end
            SQ_LOAD:  d.st = SQ_SEND;
            SQ_SEND:  if (tx_done) d.st = SQ_READY;
            SQ_READY: d.st = SQ_TURN;
            SQ_TURN:  d.st = SQ_IDLE;
            default:  d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.st)
            SQ_IDLE:          stat = HS_IDLE;
            SQ_LOAD, SQ_SEND: stat = HS_LWAIT;
            SQ_READY:         stat = HS_READY;
            SQ_TURN:          stat = HS_TURN;
            default:          stat = HS_IDLE;
        endcase
    end

    assign tx_start = (q.st == SQ_LOAD);
    assign lat_op   = q.op;
    assign lat_addr = q.addr;
    assign lat_data = q.data;
    assign last_idx = q.last;

endmodule

// File: rtl/flash_prog_bridge.sv
module flash_prog_bridge import fpb_pkg::*; #(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SCK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_autoinc,
    input  logic              cfg_dummy,
    input  logic              cfg_direct,
    input  logic              cfg_hold_host,
    input  logic [7:0]        prog_op,
    input  logic              wr_req,
    input  logic [1:0]        wr_size,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [1:0]        host_stat,
    output logic              spi_sck,
    output logic              spi_mosi,
    output logic              spi_cs_n
);

    localparam int unsigned ADDR_BYTES  = ADDR_W / 8;
    localparam int unsigned DATA_BYTES  = DATA_W / 8;
    localparam int unsigned FRAME_BYTES = 1 + ADDR_BYTES + DATA_BYTES;
    localparam int unsigned IDX_W       = $clog2(FRAME_BYTES);

    logic                        tx_start;
    logic                        tx_done;
    logic [7:0]                  lat_op;
    logic [ADDR_W-1:0]           lat_addr;
    logic [DATA_W-1:0]           lat_data;
    logic [IDX_W-1:0]            last_idx;
    logic [FRAME_BYTES-1:0][7:0] frame;
    host_stat_e                  stat;

    fpb_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .cfg_autoinc   (cfg_autoinc),
        .cfg_dummy     (cfg_dummy),
        .cfg_direct    (cfg_direct),
        .cfg_hold_host (cfg_hold_host),
        .req           (wr_req),
        .size          (wr_size),
        .addr          (wr_addr),
        .data          (wr_data),
        .opcode        (prog_op),
        .tx_done       (tx_done),
        .tx_start      (tx_start),
        .lat_op        (lat_op),
        .lat_addr      (lat_addr),
        .lat_data      (lat_data),
        .last_idx      (last_idx),
        .stat          (stat)
    );

    fpb_frame_pack #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pack (
        .opcode  (lat_op),
        .addr    (lat_addr),
        .data    (lat_data),
        .entries (frame)
    );

    fpb_spi_shift #(
        .NB       (FRAME_BYTES),
        .SCK_HALF (SCK_HALF)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (tx_start),
        .frame    (frame),
        .last_idx (last_idx),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .cs_n     (spi_cs_n),
        .done     (tx_done)
    );

    assign host_stat = stat;

endmodule

// File: rtl/fpb_checker.sv
module fpb_checker (
    input logic       clk,
    input logic       rst,
    input logic       cfg_autoinc,
    input logic       cfg_dummy,
    input logic       cfg_direct,
    input logic       cfg_hold_host,
    input logic       wr_req,
    input logic [1:0] host_stat,
    input logic       spi_sck,
    input logic       spi_cs_n
);

    logic ok_cfg;
    assign ok_cfg = !cfg_autoinc && !cfg_dummy && cfg_direct && cfg_hold_host;

    assert_reject_R1: assert property (@(posedge clk) disable iff (rst)
        (host_stat == 2'd0 && wr_req && !ok_cfg) |=> (host_stat == 2'd0));

    assert_accept_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (host_stat == 2'd0 && wr_req && ok_cfg) |=> (host_stat == 2'd1));

    assert_cs_in_wait_R2: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> (host_stat == 2'd1));

    assert_sck_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    assert_ready_after_cs_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |=> (host_stat == 2'd2));

    assert_turn_after_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (host_stat == 2'd2) |=> (host_stat == 2'd3));

    assert_idle_after_turn_R7: assert property (@(posedge clk) disable iff (rst)
        (host_stat == 2'd3) |=> (host_stat == 2'd0));

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (spi_cs_n && !spi_sck && host_stat == 2'd0));

endmodule

bind flash_prog_bridge fpb_checker u_fpb_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_autoinc   (cfg_autoinc),
    .cfg_dummy     (cfg_dummy),
    .cfg_direct    (cfg_direct),
    .cfg_hold_host (cfg_hold_host),
    .wr_req        (wr_req),
    .host_stat     (host_stat),
    .spi_sck       (spi_sck),
    .spi_cs_n      (spi_cs_n)
);

// File: tb/flash_prog_bridge_test.sv
`timescale 1ns/1ps
module flash_prog_bridge_test;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg = 4'b0011;   // {autoinc, dummy, direct, hold_host}
    logic [7:0]  prog_op = '0;
    logic        wr_req = 1'b0;
    logic [1:0]  wr_size = '0;
    logic [23:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  host_stat;
    logic        spi_sck, spi_mosi, spi_cs_n;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    flash_prog_bridge #(.ADDR_W(24), .DATA_W(32), .SCK_HALF(HALF)) uut (
        .clk           (clk),
        .rst           (rst),
        .cfg_autoinc   (cfg[3]),
        .cfg_dummy     (cfg[2]),
        .cfg_direct    (cfg[1]),
        .cfg_hold_host (cfg[0]),
        .prog_op       (prog_op),
        .wr_req        (wr_req),
        .wr_size       (wr_size),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .host_stat     (host_stat),
        .spi_sck       (spi_sck),
        .spi_mosi      (spi_mosi),
        .spi_cs_n      (spi_cs_n)
    );

    // Line monitor, sampling at the falling clock edge
    int          cyc = 0, nbits = 0, last_fall = 0, gap = 0, frame_cnt = 0;
    int          n_bad_stat = 0, n_bad_idle = 0;
    logic [63:0] bits = '0;
    logic        prev_cs = 1'b1, prev_sck = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (prev_cs && !spi_cs_n) begin nbits = 0; bits = '0; end
            if (!spi_cs_n && !prev_sck && spi_sck) begin
                bits = {bits[62:0], spi_mosi};
                nbits++;
            end
            if (prev_sck && !spi_sck) last_fall = cyc;
            if (!prev_cs && spi_cs_n) begin gap = cyc - last_fall; frame_cnt++; end
            if (!spi_cs_n && host_stat != 2'd1) n_bad_stat++;
            if (spi_cs_n && spi_sck) n_bad_idle++;
        end
        prev_cs  = spi_cs_n;
        prev_sck = spi_sck;
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] op, input logic [23:0] a,
                            input logic [31:0] d, input logic [1:0] sz, input bit disturb);
        int fc0, bs0, bi0, guard, nd, viol;
        logic [63:0] ef;
        fc0 = frame_cnt; bs0 = n_bad_stat; bi0 = n_bad_idle;
        cfg = 4'b0011; prog_op = op; wr_addr = a; wr_data = d; wr_size = sz; wr_req = 1'b1;
        step();
        wr_req = 1'b0; prog_op = ~op; wr_addr = ~a; wr_data = ~d; wr_size = ~sz;
        chk("R2 long-wait after accept", host_stat, 2'd1);
        guard = 0;
        while (frame_cnt == fc0 && guard < 4000) begin
            wr_req = (disturb && guard == 30);
            step();
            guard++;
        end
        wr_req = 1'b0;
        nd = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        ef = {op, a[23:16], a[15:8], a[7:0], d[7:0], d[15:8], d[23:16], d[31:24]};
        ef = ef >> (8 * (4 - nd));
        chk("R2 one frame sent", frame_cnt, fc0 + 1);
        chk("R4 frame bit count", nbits, 8 * (4 + nd));
        chk("R3 R5 R9 frame bits", bits, ef);
        chk("R6 cs hold after last fall", gap, 2 * HALF);
        chk("R2 status long-wait during frame", n_bad_stat - bs0, 0);
        chk("R5 sck low while deselected", n_bad_idle - bi0, 0);
        if (disturb) wr_req = 1'b1;
        step();
        chk("R7 ready after cs rise", host_stat, 2'd2);
        step();
        chk("R7 turnaround after ready", host_stat, 2'd3);
        step();
        wr_req = 1'b0;
        chk("R7 idle after turnaround", host_stat, 2'd0);
        if (disturb) begin
            viol = 0;
            for (int i = 0; i < 4 * HALF + 6; i++) begin
                step();
                if (!spi_cs_n || host_stat != 2'd0) viol++;
            end
            chk("R8 request while busy ignored", viol, 0);
            chk("R8 no extra frame", frame_cnt, fc0 + 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: all requirements, actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        chk("R10 reset cs_n", spi_cs_n, 1'b1);
        chk("R10 reset sck", spi_sck, 1'b0);
        chk("R10 reset status", host_stat, 2'd0);
        rst = 1'b0;
        step();

        // R1: sweep all enable settings
        for (int c = 0; c < 16; c++) begin
            if (c == 3) begin
                do_write(8'h02, 24'h064A70, 32'h6745_2301, 2'd2, 1'b0);
            end else begin
                int fc0;
                fc0 = frame_cnt;
                cfg = 4'(c); prog_op = 8'h02; wr_addr = 24'h12_3456; wr_data = 32'hA5A5_0F0F;
                wr_size = 2'd2; wr_req = 1'b1;
                step();
                wr_req = 1'b0;
                chk("R1 rejected status idle", host_stat, 2'd0);
                repeat (6) step();
                chk("R1 rejected no cs", spi_cs_n, 1'b1);
                chk("R1 rejected no frame", frame_cnt, fc0);
            end
        end

        // R3 R4 R5 R9: size and pattern sweep
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 4; s++) begin
                logic [7:0]  op;
                logic [23:0] a;
                logic [31:0] d;
                op = 8'(8'h02 + k * 37 + s * 5);
                a  = 24'(32'h064A70 * (k + 1) + s * 32'h0111);
                d  = 32'h0123_4567 ^ (32'h1F2E_3D4C * (k + 1)) ^ (32'(s) << 9);
                do_write(op, a, d, 2'(s), 1'b0);
            end
        end

        // R8: requests during shifting and during the handshake cycles
        do_write(8'h32, 24'hFF_00FF, 32'hDEAD_BEEF, 2'd3, 1'b1);
        do_write(8'h02, 24'h00_0001, 32'h0000_0080, 2'd0, 1'b1);

        // R10: reset in mid-frame, then recovery
        begin
            int fc0;
            cfg = 4'b0011; prog_op = 8'h02; wr_addr = 24'h55_AA55; wr_data = 32'h1234_5678;
            wr_size = 2'd2; wr_req = 1'b1;
            step();
            wr_req = 1'b0;
            repeat (40) step();
            chk("R10 frame underway before reset", spi_cs_n, 1'b0);
            rst = 1'b1;
            step();
            step();
            rst = 1'b0;
            chk("R10 mid-frame reset cs_n", spi_cs_n, 1'b1);
            chk("R10 mid-frame reset sck", spi_sck, 1'b0);
            chk("R10 mid-frame reset status", host_stat, 2'd0);
            fc0 = frame_cnt;
            repeat (8) step();
            chk("R10 stays idle after reset", {spi_cs_n, host_stat}, {1'b1, 2'd0});
            chk("R10 no frame after reset", frame_cnt, fc0);
            do_write(8'hD8, 24'hC0_FFEE, 32'h89AB_CDEF, 2'd1, 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule